// File: doc/BRIEF.md
# Receive Character Queue with Trigger and DMA Ready Signalling

This block buffers received serial characters, each with its error flags, in a 16-entry first-in first-out queue. A deserialiser pushes characters on the write port. A consumer pops them on the read port. The read data is registered and appears one cycle after the pop request.

A write-only control byte sets how the queue behaves:
- It can empty the receive queue.
- It can send a one-cycle clear pulse to the transmit queue, which lives elsewhere.
- It picks the occupancy threshold for the interrupt request.
- It picks one of two signalling modes for the receive-ready and transmit-ready outputs used by a DMA engine.

The transmit queue is seen only through two level inputs, empty and full, and these drive the transmit-ready output. Occupancy, a data-available flag and a sticky overrun flag are visible at the ports. A read-only view of the control byte shows the fields in effect.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, cfg_view is 8'h01, level is 0, data_avail, trig_irq, rx_rdy, overrun and tx_clr are low, and rd_char and rd_err are 0.
- R2: Characters leave in the order they were accepted. On a read request at a clock edge with level > 0, rd_char and rd_err show the oldest entry from that edge on, and level drops by one.
- R3: A write while level is 16 with no read in the same cycle is dropped, and overrun goes high. Overrun stays high until a receive clear. A write and a read in the same cycle while full are both accepted, and level stays 16.
- R4: A read request while level is 0 leaves rd_char, rd_err and level unchanged.
- R5: A control write with bit 1 set empties the queue at that edge: level becomes 0 and overrun becomes 0. A character written in the same cycle is dropped, and rd_char is unchanged. Bit 1 reads back as 0.
- R6: A control write with bit 2 set raises tx_clr for exactly the one cycle after the write edge. Bit 2 reads back as 0.
- R7: Control bits 7:6 select the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. trig_irq is high exactly while level is at or above the threshold. A new setting takes effect from the edge of the control write.
- R8: data_avail is high exactly while level is non-zero.
- R9: Control bit 3 selects the mode. In mode 0, rx_rdy equals data_avail. In mode 1, rx_rdy rises when level reaches the threshold and stays high until level is 0.
- R10: tx_rdy equals tx_empty in mode 0 and equals the inverse of tx_full in mode 1.
- R11: cfg_view is {bits 7:6, 2'b00, bit 3, 2'b00, 1'b1} of the last control write. Bit 0 always reads 1, and bits 5:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| cfg_view | output | 8 | Control fields in effect |
| wr_en | input | 1 | Push request |
| wr_char | input | 8 | Character to push |
| wr_err | input | 3 | Error flags of the character |
| rd_en | input | 1 | Pop request |
| rd_char | output | 8 | Last popped character |
| rd_err | output | 3 | Error flags of the last popped character |
| level | output | 5 | Occupancy, 0 to 16 |
| data_avail | output | 1 | Queue not empty |
| trig_irq | output | 1 | Occupancy at or above the threshold |
| overrun | output | 1 | Sticky dropped-write flag |
| rx_rdy | output | 1 | Receive DMA ready |
| tx_empty | input | 1 | Transmit queue empty |
| tx_full | input | 1 | Transmit queue full |
| tx_rdy | output | 1 | Transmit DMA ready |
| tx_clr | output | 1 | One-cycle transmit queue clear |

## Verification
Some rules hold on every cycle, and the assertions check these:
- level stays within bounds;
- a receive clear leaves the queue empty with overrun cleared;
- a write to a full queue is dropped and raises a sticky overrun;
- a read of an empty queue holds the output data;
- tx_clr fires only after a control write with bit 2 set;
- data_avail tracks level, and mode 0 receive-ready follows it.

Other behaviour needs the bench's scenarios. These are the character order and error flags across many pushes, the four trigger thresholds at their exact boundaries, the mode 1 hold from the threshold down to empty, the full-queue read-and-write case, and the read-back of ignored control bits.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_FOUR = 2'b01,
    TRIG_EIGHT = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_e;

  // Occupancy at which the trigger request fires
  function automatic int unsigned trig_bytes(trig_sel_e sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

  // Read-back image of the control byte
  function automatic logic [7:0] cfg_image(trig_sel_e sel, logic mode);
    return {sel, 2'b00, mode, 2'b00, 1'b1};
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output trig_sel_e  trig_sel,
  output logic       mode,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic [7:0] cfg_view
);

  trig_sel_e trig_q;
  logic      mode_q;
  logic      tx_clr_q;

  // Receive clear acts at the edge of the write itself
  assign rx_clr = ctl_we & ctl_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= TRIG_ONE;
      mode_q   <= 1'b0;
      tx_clr_q <= 1'b0;
    end else begin
      tx_clr_q <= ctl_we & ctl_wdata[2];
      if (ctl_we) begin
        trig_q <= trig_sel_e'(ctl_wdata[7:6]);
        mode_q <= ctl_wdata[3];
      end
    end
  end

  assign trig_sel = trig_q;
  assign mode     = mode_q;
  assign tx_clr   = tx_clr_q;
  assign cfg_view = cfg_image(trig_q, mode_q);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_en,
  output logic [W-1:0]  rd_word,
  output logic [CW-1:0] count,
  output logic          overrun
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rd_q;
  logic          ovr_q;
  logic          is_full, is_empty, rd_ok, wr_ok, wr_drop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full  = (cnt_q == CW'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign rd_ok    = rd_en & ~is_empty & ~clr;
  assign wr_ok    = wr_en & ~clr & (~is_full | rd_ok);
  assign wr_drop  = wr_en & ~clr & ~wr_ok;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
      rd_q  <= '0;
      ovr_q <= 1'b0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) begin
        rptr <= bump(rptr);
        rd_q <= mem[rptr];
      end
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
      if (wr_drop) ovr_q <= 1'b1;
    end
  end

  assign rd_word = rd_q;
  assign count   = cnt_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  trig_sel_e     trig_sel,
  input  logic          mode,
  input  logic          tx_empty,
  input  logic          tx_full,
  output logic          trig_irq,
  output logic          data_avail,
  output logic          rx_rdy,
  output logic          tx_rdy
);

  logic [CW-1:0] thr;
  logic          at_thr, burst_now, burst_q;

  assign thr        = CW'(trig_bytes(trig_sel));
  assign at_thr     = (count >= thr);
  assign data_avail = (count != '0);
  // Multi-transfer ready: set at threshold, held until empty
  assign burst_now  = at_thr | (burst_q & data_avail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_q <= 1'b0;
    else        burst_q <= burst_now;
  end

  assign trig_irq = at_thr;
  assign rx_rdy   = mode ? burst_now : data_avail;
  assign tx_rdy   = mode ? ~tx_full : tx_empty;

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    cfg_view,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_char,
  input  logic [EW-1:0] wr_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_char,
  output logic [EW-1:0] rd_err,
  output logic [CW-1:0] level,
  output logic          data_avail,
  output logic          trig_irq,
  output logic          overrun,
  output logic          rx_rdy,
  input  logic          tx_empty,
  input  logic          tx_full,
  output logic          tx_rdy,
  output logic          tx_clr
);

  trig_sel_e     trig_sel;
  logic          rx_mode;
  logic          rx_clr_evt;
  logic [CW-1:0] count;

  rxq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .trig_sel(trig_sel), .mode(rx_mode), .rx_clr(rx_clr_evt),
    .tx_clr(tx_clr), .cfg_view(cfg_view)
  );

  rxq_store #(.DEPTH(DEPTH), .W(DW + EW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr_evt), .wr_en(wr_en),
    .wr_word({wr_err, wr_char}), .rd_en(rd_en),
    .rd_word({rd_err, rd_char}), .count(count), .overrun(overrun)
  );

  rxq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .trig_sel(trig_sel),
    .mode(rx_mode), .tx_empty(tx_empty), .tx_full(tx_full),
    .trig_irq(trig_irq), .data_avail(data_avail), .rx_rdy(rx_rdy),
    .tx_rdy(tx_rdy)
  );

  assign level = count;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic          wr_en,
  input logic          rd_en,
  input logic [CW-1:0] level,
  input logic          data_avail,
  input logic [DW-1:0] rd_char,
  input logic          overrun,
  input logic          tx_clr,
  input logic          rx_rdy,
  input logic          rx_mode,
  input logic          rx_clr_evt
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr_evt |=> (level == '0 && !overrun)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !rx_clr_evt && level == CW'(DEPTH)) |=> (overrun && level == CW'(DEPTH))); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rx_clr_evt) |=> overrun); // R3
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |=> $stable(rd_char)); // R4
  AST_TX_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |-> $past(ctl_we && ctl_wdata[2])); // R6
  AST_AVAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail == (level != '0)); // R8
  AST_MODE0_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |-> (rx_rdy == data_avail)); // R9

endmodule

bind rx_char_queue rxq_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .wr_en(wr_en), .rd_en(rd_en), .level(level), .data_avail(data_avail),
  .rd_char(rd_char), .overrun(overrun), .tx_clr(tx_clr), .rx_rdy(rx_rdy),
  .rx_mode(rx_mode), .rx_clr_evt(rx_clr_evt)
);

// File: tb/sim_rx_char_queue.sv
module sim_rx_char_queue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] cfg_view;
  logic       wr_en = 1'b0;
  logic [7:0] wr_char = '0;
  logic [2:0] wr_err = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_char;
  logic [2:0] rd_err;
  logic [4:0] level;
  logic       data_avail, trig_irq, overrun, rx_rdy, tx_rdy, tx_clr;
  logic       tx_empty = 1'b1;
  logic       tx_full = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt  = 0;
  logic [10:0] exp_q[$];
  logic [10:0] last_rd = '0;
  event pop_ev;

  always #2 clk = ~clk;

  rx_char_queue u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  // Driver: pushes one character and records the expected entry
  task automatic push(input logic [7:0] c, input logic [2:0] e);
    @(negedge clk); wr_en = 1'b1; wr_char = c; wr_err = e;
    @(negedge clk); wr_en = 1'b0;
    if (mcnt < 16) begin exp_q.push_back({e, c}); mcnt++; end
  endtask

  task automatic pull();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    if (mcnt > 0) begin mcnt--; ->pop_ev; end
  endtask

  // Monitor: compares each popped entry with the scoreboard
  initial forever begin
    @(pop_ev);
    begin
      logic [10:0] expv;
      expv = exp_q.pop_front();
      chk({rd_err, rd_char} == expv, "R2 order", {rd_err, rd_char}, expv);
      last_rd = expv;
    end
  end

  task automatic drain();
    while (mcnt > 0) pull();
    #0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_view == 8'h01, "R1 cfg_view", cfg_view, 8'h01);
    chk(level == 0 && !data_avail && !trig_irq && !rx_rdy && !overrun && !tx_clr,
        "R1 flags", {level, data_avail, trig_irq, rx_rdy, overrun, tx_clr}, 0);
    chk(rd_char == 0 && rd_err == 0, "R1 read data", rd_char, 0);
    chk(tx_rdy == 1'b1, "R10 mode0 tx_empty", tx_rdy, 1);

    // Basic order, trigger 1, mode 0
    push(8'hA1, 3'd1); push(8'h52, 3'd0); push(8'h3C, 3'd6);
    chk(level == 3, "R2 level", level, 3);
    chk(data_avail, "R8 avail", data_avail, 1);
    chk(trig_irq, "R7 thr 1", trig_irq, 1);
    chk(rx_rdy, "R9 mode0 rdy", rx_rdy, 1);
    drain();
    chk(!data_avail && !rx_rdy && !trig_irq, "R8 empty flags", data_avail, 0);
    pull(); // empty read
    chk(rd_char == last_rd[7:0] && rd_err == last_rd[10:8], "R4 hold", rd_char, last_rd[7:0]);
    chk(level == 0, "R4 level", level, 0);

    // Threshold 4
    ctl(8'h40);
    chk(cfg_view == 8'h41, "R11 view", cfg_view, 8'h41);
    for (int i = 0; i < 3; i++) push(8'(8'h10 + i), 3'(i));
    chk(!trig_irq, "R7 thr4 below", trig_irq, 0);
    push(8'h13, 3'd2);
    chk(trig_irq, "R7 thr4 at", trig_irq, 1);
    pull();
    chk(!trig_irq, "R7 thr4 after read", trig_irq, 0);
    drain();

    // Threshold 8
    ctl(8'h80);
    for (int i = 0; i < 7; i++) push(8'(8'h20 + i), 3'd0);
    chk(!trig_irq, "R7 thr8 below", trig_irq, 0);
    push(8'h27, 3'd5);
    chk(trig_irq, "R7 thr8 at", trig_irq, 1);
    drain();

    // Threshold 14, fill, overrun; reserved bits ignored
    ctl(8'hF0);
    chk(cfg_view == 8'hC1, "R11 reserved ignored", cfg_view, 8'hC1);
    for (int i = 0; i < 13; i++) push(8'(8'h40 + i), 3'(i));
    chk(!trig_irq, "R7 thr14 below", trig_irq, 0);
    push(8'h4D, 3'd3);
    chk(trig_irq, "R7 thr14 at", trig_irq, 1);
    push(8'h4E, 3'd0); push(8'h4F, 3'd7);
    chk(level == 16 && !overrun, "R3 full", level, 16);
    push(8'hEE, 3'd7); // dropped
    chk(overrun && level == 16, "R3 overrun", {overrun, level}, {1'b1, 5'd16});
    drain();
    chk(overrun, "R3 sticky", overrun, 1);

    // Receive clear with a simultaneous write
    push(8'h61, 3'd0); push(8'h62, 3'd0);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h02; wr_en = 1'b1; wr_char = 8'h99;
    @(negedge clk); ctl_we = 1'b0; wr_en = 1'b0;
    exp_q.delete(); mcnt = 0;
    chk(level == 0 && !overrun, "R5 cleared", {overrun, level}, 0);
    chk(cfg_view == 8'h01, "R5 bit1 reads 0", cfg_view, 8'h01);
    chk(rd_char == last_rd[7:0], "R5 rd_char kept", rd_char, last_rd[7:0]);

    // Transmit clear pulse
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h04;
    @(negedge clk); ctl_we = 1'b0;
    chk(tx_clr, "R6 pulse high", tx_clr, 1);
    chk(cfg_view == 8'h01, "R6 bit2 reads 0", cfg_view, 8'h01);
    @(negedge clk);
    chk(!tx_clr, "R6 pulse one cycle", tx_clr, 0);

    // Mode 0 transmit ready, then mode 1 with threshold 4
    tx_empty = 1'b0; #1;
    chk(!tx_rdy, "R10 mode0 not empty", tx_rdy, 0);
    ctl(8'h48);
    chk(cfg_view == 8'h49, "R11 mode view", cfg_view, 8'h49);
    chk(tx_rdy, "R10 mode1 not full", tx_rdy, 1);
    tx_full = 1'b1; #1;
    chk(!tx_rdy, "R10 mode1 full", tx_rdy, 0);
    push(8'h71, 3'd0);
    chk(!rx_rdy, "R9 mode1 below thr", rx_rdy, 0);
    push(8'h72, 3'd0); push(8'h73, 3'd0); push(8'h74, 3'd1);
    chk(rx_rdy, "R9 mode1 at thr", rx_rdy, 1);
    pull(); pull();
    chk(rx_rdy && level == 2, "R9 mode1 held", rx_rdy, 1);
    drain();
    chk(!rx_rdy, "R9 mode1 empty", rx_rdy, 0);

    // Full queue with simultaneous read and write
    ctl(8'hC0);
    for (int i = 0; i < 16; i++) push(8'(8'h80 + i), 3'(i));
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_char = 8'hB7; wr_err = 3'd4;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    exp_q.push_back({3'd4, 8'hB7});
    ->pop_ev;
    #0;
    chk(level == 16 && !overrun, "R3 full read+write", {overrun, level}, 16);
    drain();
    chk(level == 0, "R2 drained", level, 0);

    finish_run();
  end

endmodule